// File: doc/BRIEF.md
# Write-back write-allocate data cache controller

This block is a small direct-mapped data cache that sits between a processor load/store port and a slow backing memory. Data is stored byte-wide on a 5-bit byte-address bus. A line holds two bytes. Stores are kept in the cache only, and the line is marked dirty. Any miss, whether a load or a store, first allocates the line by fetching the whole block from memory. A store that missed then merges into the fetched line.

When a miss displaces a dirty line, the victim is not written out on the spot. The whole line moves into a short queue of pending write-backs, and the refill starts at once. The queue drains to memory one byte per write, oldest line first, while the processor keeps running. A miss on a line that is still waiting in the queue takes its data from the youngest matching entry and does not read memory. Memory therefore never returns a stale copy.

The processor holds its request until the cache raises ready. A hit completes in the same cycle. A miss keeps ready low until the line has been filled.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid, the write-back queue is empty, and neither `mem_rd_req` nor `mem_wr_valid` is asserted. The first access to any address is therefore a miss.
- R2: A load that hits raises `cpu_ready` in the cycle of the request and returns the addressed byte on `cpu_rdata` in that cycle.
- R3: The address is split as follows: bit 0 is the byte within the line, bits 2:1 are the line index, and bits 4:3 are the tag.
- R4: On a miss, `cpu_ready` stays low until the refill ends. The refill is exactly one block read of line address `cpu_addr[4:1]`, and it leaves the line valid and clean.
- R5: A store that hits, or that completes after allocation, updates only the addressed byte in the cache and marks the line dirty. No memory write is issued for it.
- R6: A clean line that is displaced is dropped without any memory write.
- R7: A dirty line that is displaced is appended to the tail of the write-back queue. It is written out as two byte writes to addresses `{line, 0}` and then `{line, 1}`.
- R8: The queue drains oldest entry first, so memory ends up holding the newest data of every address.
- R9: The queue holds 4 lines. A dirty eviction while the queue is full stalls the processor, with `cpu_ready` low, until an entry leaves.
- R10: While `mem_wr_valid` is high, `mem_wr_addr` and `mem_wr_data` hold steady until `mem_wr_ack`. Each ack completes one byte, and the entry leaves the queue on the ack of its second byte.
- R11: A miss whose line address matches a queued line is filled from the youngest matching entry, with no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 5 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Access completes on this edge |
| cpu_rdata | output | 8 | Load byte, valid with `cpu_ready` |
| mem_rd_req | output | 1 | Block read request, held until `mem_rd_valid` |
| mem_rd_laddr | output | 4 | Line address of the block read |
| mem_rd_valid | input | 1 | One-cycle pulse carrying the block |
| mem_rd_data | input | 16 | Block; byte 0 in bits 7:0 |
| mem_wr_valid | output | 1 | Byte write pending |
| mem_wr_addr | output | 5 | Byte address of the write |
| mem_wr_data | output | 8 | Byte to write |
| mem_wr_ack | input | 1 | One-cycle pulse: the pending write is done |

## Verification
The assertions assume two things about the neighbours. The processor holds `cpu_addr`, `cpu_we` and `cpu_wdata` steady while `cpu_req` waits for `cpu_ready`. Memory pulses `mem_rd_valid` only while a read is requested, and `mem_wr_ack` only while a write is pending, each for a single cycle. The bench's memory model answers after a random delay but never pulses outside a request, and its access task changes processor inputs only between transactions. Directed phases hold memory writes back to fill the queue and to force queue hits. A random phase then mixes loads and stores over all 32 addresses against a reference byte array.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [0:0] {ST_LOOK = 1'b0, ST_FILL = 1'b1} wbc_state_e;
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
   parameter int LINES  = 4,
   parameter int TAG_W  = 2,
   parameter int LINE_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic              wr_dirty,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_data
);
   logic [LINES-1:0]  vld_q, drt_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] data_q [LINES];

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_chk_lines
      $error("wbc_line_store: LINES must be a power of two >= 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         drt_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= wr_valid;
         drt_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign rd_dirty = drt_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];

   for (genvar i = 0; i < LINES; i++) begin : g_line_chk
      // R5: a dirty mark only ever sits on a valid line
      a_r5_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
         drt_q[i] |-> vld_q[i]);
   end
endmodule

// File: rtl/wbc_wb_queue.sv
module wbc_wb_queue #(
   parameter int DEPTH   = 4,
   parameter int LADDR_W = 4,
   parameter int WORD_W  = 8,
   parameter int WPL     = 2,
   localparam int OFF_W  = $clog2(WPL),
   localparam int LINE_W = WORD_W * WPL,
   localparam int Q_W    = $clog2(DEPTH),
   localparam int CNT_W  = Q_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [LADDR_W-1:0]       push_laddr,
   input  logic [LINE_W-1:0]        push_data,
   input  logic [LADDR_W-1:0]       look_laddr,
   output logic                     look_hit,
   output logic [LINE_W-1:0]        look_data,
   output logic                     full,
   output logic                     mem_wr_valid,
   output logic [LADDR_W+OFF_W-1:0] mem_wr_addr,
   output logic [WORD_W-1:0]        mem_wr_data,
   input  logic                     mem_wr_ack
);
   logic [LADDR_W-1:0] laddr_q [DEPTH];
   logic [LINE_W-1:0]  line_q  [DEPTH];
   logic [Q_W-1:0]     head_q, tail_q;
   logic [CNT_W-1:0]   count_q;
   logic [OFF_W-1:0]   widx_q;
   logic               last_word, pop;

   if (DEPTH < 2 || (1 << Q_W) != DEPTH) begin : g_chk_depth
      $error("wbc_wb_queue: DEPTH must be a power of two >= 2");
   end
   if (WPL < 2 || (1 << OFF_W) != WPL) begin : g_chk_wpl
      $error("wbc_wb_queue: WPL must be a power of two >= 2");
   end

   assign full         = (count_q == CNT_W'(DEPTH));
   assign mem_wr_valid = (count_q != '0);
   assign mem_wr_addr  = {laddr_q[head_q], widx_q};
   assign mem_wr_data  = line_q[head_q][widx_q*WORD_W +: WORD_W];
   assign last_word    = (widx_q == OFF_W'(WPL - 1));
   assign pop          = mem_wr_valid && mem_wr_ack && last_word;

   // search oldest to youngest so the youngest match wins
   always_comb begin
      look_hit  = 1'b0;
      look_data = '0;
      for (int a = 0; a < DEPTH; a++) begin
         logic [Q_W-1:0] slot;
         slot = head_q + Q_W'(a);
         if (CNT_W'(a) < count_q && laddr_q[slot] == look_laddr) begin
            look_hit  = 1'b1;
            look_data = line_q[slot];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         widx_q  <= '0;
      end else begin
         if (push) tail_q <= tail_q + 1'b1;
         if (pop)  head_q <= head_q + 1'b1;
         count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
         if (mem_wr_valid && mem_wr_ack) widx_q <= widx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         laddr_q[tail_q] <= push_laddr;
         line_q[tail_q]  <= push_data;
      end
   end

   // R9: the controller never appends to a full queue
   a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R10: a pending byte write stays put until memory acknowledges it
   a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ack) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache #(
   parameter int ADDR_W   = 5,
   parameter int WORD_W   = 8,
   parameter int WPL      = 2,
   parameter int LINES    = 4,
   parameter int Q_DEPTH  = 4,
   localparam int OFF_W   = $clog2(WPL),
   localparam int IDX_W   = $clog2(LINES),
   localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
   localparam int LADDR_W = ADDR_W - OFF_W,
   localparam int LINE_W  = WORD_W * WPL
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [WORD_W-1:0]  cpu_wdata,
   output logic               cpu_ready,
   output logic [WORD_W-1:0]  cpu_rdata,
   output logic               mem_rd_req,
   output logic [LADDR_W-1:0] mem_rd_laddr,
   input  logic               mem_rd_valid,
   input  logic [LINE_W-1:0]  mem_rd_data,
   output logic               mem_wr_valid,
   output logic [ADDR_W-1:0]  mem_wr_addr,
   output logic [WORD_W-1:0]  mem_wr_data,
   input  logic               mem_wr_ack
);
   import wbc_pkg::*;

   if (TAG_W < 1) begin : g_chk_tag
      $error("wbc_cache: address too narrow for LINES and WPL");
   end

   wbc_state_e         state_q;
   logic [LADDR_W-1:0] fill_laddr_q;

   logic [OFF_W-1:0]   off;
   logic [IDX_W-1:0]   idx;
   logic [TAG_W-1:0]   tag;
   logic [LADDR_W-1:0] laddr, look_laddr;

   logic               ln_valid, ln_dirty;
   logic [TAG_W-1:0]   ln_tag;
   logic [LINE_W-1:0]  ln_data, merged;

   logic               hit, miss, victim_dirty, q_full, miss_go, q_push, q_hit, fwd;
   logic [LINE_W-1:0]  q_data;

   logic               wr_en, wr_valid, wr_dirty;
   logic [IDX_W-1:0]   wr_idx;
   logic [TAG_W-1:0]   wr_tag;
   logic [LINE_W-1:0]  wr_data;

   assign off   = cpu_addr[OFF_W-1:0];
   assign idx   = cpu_addr[OFF_W +: IDX_W];
   assign tag   = cpu_addr[ADDR_W-1 -: TAG_W];
   assign laddr = cpu_addr[ADDR_W-1:OFF_W];

   wbc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_lines (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(idx), .rd_valid(ln_valid), .rd_dirty(ln_dirty), .rd_tag(ln_tag), .rd_data(ln_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
      .wr_tag(wr_tag), .wr_data(wr_data)
   );

   wbc_wb_queue #(.DEPTH(Q_DEPTH), .LADDR_W(LADDR_W), .WORD_W(WORD_W), .WPL(WPL)) u_wbq (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_laddr({ln_tag, idx}), .push_data(ln_data),
      .look_laddr(look_laddr), .look_hit(q_hit), .look_data(q_data),
      .full(q_full),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   assign hit          = ln_valid && (ln_tag == tag);
   assign cpu_ready    = (state_q == ST_LOOK) && cpu_req && hit;
   assign cpu_rdata    = ln_data[off*WORD_W +: WORD_W];
   assign miss         = (state_q == ST_LOOK) && cpu_req && !hit;
   assign victim_dirty = ln_valid && ln_dirty;
   assign miss_go      = miss && !(victim_dirty && q_full);
   assign q_push       = miss_go && victim_dirty;
   assign look_laddr   = (state_q == ST_FILL) ? fill_laddr_q : laddr;
   assign fwd          = miss_go && q_hit;
   assign mem_rd_req   = (state_q == ST_FILL);
   assign mem_rd_laddr = fill_laddr_q;

   always_comb begin
      merged = ln_data;
      merged[off*WORD_W +: WORD_W] = cpu_wdata;
   end

   // single update port: store hit, queue forward, invalidate, or refill
   always_comb begin
      wr_en    = 1'b0;
      wr_idx   = idx;
      wr_valid = 1'b0;
      wr_dirty = 1'b0;
      wr_tag   = tag;
      wr_data  = ln_data;
      if (cpu_ready && cpu_we) begin
         wr_en    = 1'b1;
         wr_valid = 1'b1;
         wr_dirty = 1'b1;
         wr_data  = merged;
      end else if (fwd) begin
         wr_en    = 1'b1;
         wr_valid = 1'b1;
         wr_data  = q_data;
      end else if (miss_go) begin
         wr_en    = 1'b1;
         wr_tag   = ln_tag;
      end else if (state_q == ST_FILL && mem_rd_valid) begin
         wr_en    = 1'b1;
         wr_idx   = fill_laddr_q[IDX_W-1:0];
         wr_valid = 1'b1;
         wr_tag   = fill_laddr_q[LADDR_W-1 -: TAG_W];
         wr_data  = mem_rd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_LOOK;
         fill_laddr_q <= '0;
      end else begin
         case (state_q)
            ST_LOOK: if (miss_go && !q_hit) begin
               state_q      <= ST_FILL;
               fill_laddr_q <= laddr;
            end
            ST_FILL: if (mem_rd_valid) state_q <= ST_LOOK;
            default: state_q <= ST_LOOK;
         endcase
      end
   end

   // R4: a block read request and its address hold until the data arrives
   a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_laddr)));
   // R4: the processor is never released while a refill is outstanding
   a_r4_no_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !cpu_ready);
   // R11: memory is never read for a line that is still queued
   a_r11_no_fetch_of_queued: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !q_hit);
endmodule

// File: tb/sim_wbc_cache.sv
module sim_wbc_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [4:0]  cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_ready;
   logic [7:0]  cpu_rdata;
   logic        mem_rd_req;
   logic [3:0]  mem_rd_laddr;
   logic        mem_rd_valid = 1'b0;
   logic [15:0] mem_rd_data = '0;
   logic        mem_wr_valid;
   logic [4:0]  mem_wr_addr;
   logic [7:0]  mem_wr_data;
   logic        mem_wr_ack = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   wbc_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_rd_req(mem_rd_req), .mem_rd_laddr(mem_rd_laddr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   int         checks = 0, errors = 0;
   logic [7:0] bmem [32];
   logic [7:0] ref_mem [32];
   logic [4:0] wr_log [256];
   int         wr_cnt = 0, rd_cnt = 0;
   bit         hold_wr = 1'b0;
   int         rd_wait = 0, wr_wait = 0;
   int         cycles = 0;
   bit         st_done;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // backing memory: random latency, single-cycle response pulses
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rd_valid) mem_rd_valid = 1'b0;
         else if (mem_rd_req) begin
            if (rd_wait == 0) begin
               mem_rd_data  = {bmem[{mem_rd_laddr, 1'b1}], bmem[{mem_rd_laddr, 1'b0}]};
               mem_rd_valid = 1'b1;
               rd_cnt++;
               rd_wait = $urandom % 3;
            end else rd_wait--;
         end
         if (mem_wr_ack) mem_wr_ack = 1'b0;
         else if (mem_wr_valid && !hold_wr) begin
            if (wr_wait == 0) begin
               bmem[mem_wr_addr] = mem_wr_data;
               wr_log[wr_cnt % 256] = mem_wr_addr;
               wr_cnt++;
               mem_wr_ack = 1'b1;
               wr_wait = $urandom % 3;
            end else wr_wait--;
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=%0d expected=<150000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic access(input bit we, input logic [4:0] a, input logic [7:0] d,
                         output logic [7:0] q, output int waited);
      bit got;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      waited = 0; got = 1'b0;
      while (!got && waited < 5000) begin
         #3;
         if (cpu_ready) got = 1'b1;
         else begin
            @(negedge clk);
            waited++;
         end
      end
      q = cpu_rdata;
      if (!got) chk("R4", 32'd0, 32'd1);
      @(posedge clk);
      #1 cpu_req = 1'b0;
      if (we) ref_mem[a] = d;
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 400 && mem_wr_valid; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      logic [7:0] q;
      int w, r0, w0, base;
      logic [4:0] a1;
      void'($urandom(32'd20250611));
      for (int i = 0; i < 32; i++) begin
         bmem[i] = 8'($urandom);
         ref_mem[i] = bmem[i];
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #3;
      chk("R1", mem_rd_req, 0);
      chk("R1", mem_wr_valid, 0);

      // R1/R4: first load misses, one block read, ready held low
      r0 = rd_cnt;
      access(0, 5'd1, 8'h0, q, w);
      chk("R1", (w > 0), 1);
      chk("R4", rd_cnt - r0, 1);
      chk("R4", q, ref_mem[1]);
      // R2/R3: neighbour byte of the same line hits at once
      access(0, 5'd0, 8'h0, q, w);
      chk("R2", w, 0);
      chk("R3", q, ref_mem[0]);

      // R5: store hit stays in the cache
      w0 = wr_cnt;
      access(1, 5'd0, 8'hA5, q, w);
      chk("R5", w, 0);
      repeat (10) @(negedge clk);
      chk("R5", wr_cnt - w0, 0);
      chk("R5", (bmem[0] == 8'hA5), (ref_mem[0] == bmem[0] && 8'hA5 == bmem[0]));
      access(0, 5'd0, 8'h0, q, w);
      chk("R5", q, 8'hA5);

      // R6: clean victim dropped
      access(0, 5'd3, 8'h0, q, w);
      w0 = wr_cnt;
      access(0, 5'd11, 8'h0, q, w);
      repeat (10) @(negedge clk);
      chk("R6", wr_cnt - w0, 0);
      chk("R3", q, ref_mem[11]);

      // R7: dirty victim written back as two bytes, low offset first
      w0 = wr_cnt;
      access(0, 5'd8, 8'h0, q, w);
      wait_drain();
      chk("R7", wr_cnt - w0, 2);
      chk("R7", wr_log[w0 % 256], 5'd0);
      chk("R7", wr_log[(w0 + 1) % 256], 5'd1);
      chk("R7", bmem[0], 8'hA5);

      // R11: queued lines are forwarded, youngest first
      hold_wr = 1'b1;
      access(1, 5'd2, 8'h3C, q, w);
      access(0, 5'd10, 8'h0, q, w);
      r0 = rd_cnt;
      access(0, 5'd2, 8'h0, q, w);
      chk("R11", rd_cnt - r0, 0);
      chk("R11", q, 8'h3C);
      access(1, 5'd3, 8'h77, q, w);
      access(0, 5'd10, 8'h0, q, w);
      r0 = rd_cnt;
      access(0, 5'd3, 8'h0, q, w);
      chk("R11", rd_cnt - r0, 0);
      chk("R11", q, 8'h77);
      hold_wr = 1'b0;
      wait_drain();
      chk("R8", bmem[3], 8'h77);
      chk("R8", bmem[2], 8'h3C);

      // R9/R10/R8: fill the queue, stall, then check the drain order
      access(1, 5'd0, 8'h11, q, w);
      access(1, 5'd2, 8'h22, q, w);
      access(1, 5'd4, 8'h33, q, w);
      access(1, 5'd6, 8'h44, q, w);
      wait_drain();
      hold_wr = 1'b1;
      base = wr_cnt;
      access(1, 5'd8, 8'h55, q, w);
      access(1, 5'd10, 8'h66, q, w);
      access(1, 5'd12, 8'h77, q, w);
      access(1, 5'd14, 8'h88, q, w);
      st_done = 1'b0;
      fork
         begin
            access(1, 5'd16, 8'h5E, q, w);
            st_done = 1'b1;
         end
         begin
            repeat (30) @(negedge clk);
            #3;
            chk("R9", st_done, 0);
            chk("R9", cpu_ready, 0);
            chk("R10", mem_wr_valid, 1);
            a1 = mem_wr_addr;
            @(negedge clk); #3;
            chk("R10", mem_wr_addr, a1);
            chk("R10", a1, 5'd0);
            hold_wr = 1'b0;
         end
      join
      chk("R9", st_done, 1);
      wait_drain();
      chk("R8", wr_cnt - base, 10);
      for (int k = 0; k < 10; k++) chk("R8", wr_log[(base + k) % 256], 32'(k));

      // random mix checked against the reference array
      for (int n = 0; n < 400; n++) begin
         logic [4:0] ra;
         logic [7:0] rd;
         bit rw;
         ra = 5'($urandom);
         rd = 8'($urandom);
         rw = 1'($urandom);
         if (rw) access(1, ra, rd, q, w);
         else begin
            access(0, ra, 8'h0, q, w);
            chk("R8", q, ref_mem[ra]);
         end
      end
      for (int i = 0; i < 32; i++) begin
         access(0, 5'(i), 8'h0, q, w);
         chk("R8", q, ref_mem[i]);
      end
      wait_drain();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule